// File: doc/BRIEF.md
# PLL Lock Acquisition Sequencer

This block steers a disciplined-oscillator phase-locked loop from power-up to a tracked lock. It holds the loop open while the reference and the oscillator warm up and the detected signal grows. It then closes the loop with a wide phase/frequency detector at the largest bandwidth and the fastest subsample rate. When the smoothed phase-error metric shows the loop has settled, it changes to the narrow phase detector and the user's bandwidth.

The metric is produced outside this block, together with a valid strobe. The metric is compared on each strobe against two unsigned thresholds, and the lock threshold must be larger than the warning threshold. If the metric exceeds the warning threshold while the loop is locked, the lock LED goes dark for a programmable number of cycles and the loop stays closed. If the metric exceeds the lock threshold, lock is treated as lost and acquisition starts again. A one-cycle-wide request right after reset tells the surrounding logic to reload the saved integrator value.

Top module: `lock_seq`

## Requirements
- R1: While reset is held and after it is released, the state code is 0 (idle), the loop is open, the LED is off, and the wide detector and maximum bandwidth are selected. `restore_o` is high from reset release until the first rising clock edge, and low after that edge.
- R2: In idle, the state becomes 1 (acquire) on the clock edge at which `ref_warm_i`, `osc_warm_i` and `sig_level_i > sig_thr_i` all hold. If any one of them is missing, the state stays at idle.
- R3: In acquire, `pfd_wide_o`=1, `max_bw_o`=1, `loop_closed_o`=1 and `led_o`=0.
- R4: In acquire, the state becomes 2 (locked) on an edge where `metric_vld_i`=1 and `metric_i < lock_thr_i`. A metric presented without the strobe has no effect.
- R5: In locked, `pfd_wide_o`=0, `max_bw_o`=0, `loop_closed_o`=1 and `led_o`=1.
- R6: In locked, a strobe with `warn_thr_i < metric_i <= lock_thr_i` moves the state to 3 (warning).
- R7: In locked or warning, a strobe with `metric_i > lock_thr_i` moves the state to acquire. This takes priority over the warning.
- R8: Warning lasts exactly max(`flash_len_i`,1) cycles and then returns to locked. During warning, `led_o`=0, `pfd_wide_o`=0, `max_bw_o`=0 and `loop_closed_o`=1.
- R9: `state_o` encodes idle=0, acquire=1, locked=2, warning=3. Acquire is left only for locked, and warning is entered only from locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_warm_i | input | 1 | Reference warmed up |
| osc_warm_i | input | 1 | Oscillator supply current below its limit |
| sig_level_i | input | 16 | Detected signal level, \|I\|+\|Q\| |
| sig_thr_i | input | 16 | Signal level that must be exceeded |
| metric_vld_i | input | 1 | Strobe qualifying `metric_i` |
| metric_i | input | 16 | Smoothed phase-error magnitude |
| lock_thr_i | input | 16 | Lock / loss threshold |
| warn_thr_i | input | 16 | Warning threshold, lower than `lock_thr_i` |
| flash_len_i | input | 8 | Warning flash length in cycles (0 acts as 1) |
| restore_o | output | 1 | Request to reload the saved integrator |
| pfd_wide_o | output | 1 | 1 = phase/frequency detector, 0 = narrow detector |
| max_bw_o | output | 1 | 1 = maximum bandwidth and subsample rate, 0 = user setting |
| loop_closed_o | output | 1 | 1 = loop closed |
| led_o | output | 1 | Lock LED drive |
| state_o | output | 2 | State code |

## Verification
The hardest cases to reach are the warning state's own exits. One is a loss of lock that arrives during the flash, before its timer ends. The other is a metric equal to the lock threshold, which must give a warning and not a loss. Directed sequences walk the block through idle, acquire and locked, then place strobes at chosen cycles inside a three-cycle flash and at the exact threshold value. A seeded random phase follows. It holds the threshold pair apart and sweeps the metric across both thresholds with a sparse strobe, so that flashes are often cut short and the flash length changes between flashes.

// File: rtl/lock_seq_pkg.sv
package lock_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_LOCK = 2'd2,
    ST_WARN = 2'd3
  } lk_state_e;
endpackage

// File: rtl/lk_ready.sv
module lk_ready #(
  parameter int SIG_W = 16
) (
  input  logic             ref_warm_i,
  input  logic             osc_warm_i,
  input  logic [SIG_W-1:0] level_i,
  input  logic [SIG_W-1:0] thr_i,
  output logic             ready_o
);
  always_comb ready_o = ref_warm_i && osc_warm_i && (level_i > thr_i);
endmodule

// File: rtl/lk_metric_cmp.sv
module lk_metric_cmp #(
  parameter int MET_W = 16
) (
  input  logic             vld_i,
  input  logic [MET_W-1:0] metric_i,
  input  logic [MET_W-1:0] lock_thr_i,
  input  logic [MET_W-1:0] warn_thr_i,
  output logic             below_lock_o,
  output logic             over_lock_o,
  output logic             over_warn_o
);
  // events only exist on a strobe
  always_comb begin
    below_lock_o = vld_i && (metric_i < lock_thr_i);
    over_lock_o  = vld_i && (metric_i > lock_thr_i);
    over_warn_o  = vld_i && (metric_i > warn_thr_i);
  end
endmodule

// File: rtl/lk_flash.sv
module lk_flash #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  localparam int CW = LEN_W + 1;

  logic [LEN_W-1:0] cnt_q;
  logic [CW-1:0]    eff_len;

  always_comb begin
    eff_len = (len_i == '0) ? CW'(1) : {1'b0, len_i};
    done_o  = busy_i && (({1'b0, cnt_q} + CW'(1)) >= eff_len);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!busy_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + LEN_W'(1);
  end

  // R8: the elapsed count never runs past the flash length
  p_flash_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ({1'b0, cnt_q} < eff_len));
  // R8: the counter is cleared while no flash is running
  p_flash_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (cnt_q == '0));
endmodule

// File: rtl/lock_seq.sv
module lock_seq
  import lock_seq_pkg::*;
#(
  parameter int SIG_W = 16,
  parameter int MET_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_warm_i,
  input  logic             osc_warm_i,
  input  logic [SIG_W-1:0] sig_level_i,
  input  logic [SIG_W-1:0] sig_thr_i,
  input  logic             metric_vld_i,
  input  logic [MET_W-1:0] metric_i,
  input  logic [MET_W-1:0] lock_thr_i,
  input  logic [MET_W-1:0] warn_thr_i,
  input  logic [LEN_W-1:0] flash_len_i,
  output logic             restore_o,
  output logic             pfd_wide_o,
  output logic             max_bw_o,
  output logic             loop_closed_o,
  output logic             led_o,
  output logic [1:0]       state_o
);
  lk_state_e st_q, st_d;
  logic ready, below_lock, over_lock, over_warn, flash_done;
  logic started_q;

  lk_ready #(.SIG_W(SIG_W)) u_ready (
    .ref_warm_i (ref_warm_i),
    .osc_warm_i (osc_warm_i),
    .level_i    (sig_level_i),
    .thr_i      (sig_thr_i),
    .ready_o    (ready)
  );

  lk_metric_cmp #(.MET_W(MET_W)) u_cmp (
    .vld_i        (metric_vld_i),
    .metric_i     (metric_i),
    .lock_thr_i   (lock_thr_i),
    .warn_thr_i   (warn_thr_i),
    .below_lock_o (below_lock),
    .over_lock_o  (over_lock),
    .over_warn_o  (over_warn)
  );

  lk_flash #(.LEN_W(LEN_W)) u_flash (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (st_q == ST_WARN),
    .len_i  (flash_len_i),
    .done_o (flash_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (ready) st_d = ST_ACQ;
      ST_ACQ:  if (below_lock) st_d = ST_LOCK;
      ST_LOCK: begin
        if (over_lock)      st_d = ST_ACQ;
        else if (over_warn) st_d = ST_WARN;
      end
      ST_WARN: begin
        if (over_lock)       st_d = ST_ACQ;
        else if (flash_done) st_d = ST_LOCK;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      started_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      started_q <= 1'b1;
    end
  end

  always_comb begin
    restore_o     = !started_q;
    pfd_wide_o    = (st_q == ST_IDLE) || (st_q == ST_ACQ);
    max_bw_o      = (st_q == ST_IDLE) || (st_q == ST_ACQ);
    loop_closed_o = (st_q != ST_IDLE);
    led_o         = (st_q == ST_LOCK);
    state_o       = st_q;
  end

  // R2: idle is held while any start condition is missing
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !(ref_warm_i && osc_warm_i && sig_level_i > sig_thr_i))
    |=> st_q == ST_IDLE);
  // R4: acquire is left only towards locked
  p_acq_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACQ) |=> (st_q == ST_ACQ || st_q == ST_LOCK));
  // R7: a strobe above the lock threshold drops lock
  p_lost_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_LOCK || st_q == ST_WARN) && metric_vld_i && metric_i > lock_thr_i)
    |=> st_q == ST_ACQ);
  // R9: warning is entered only from locked
  p_warn_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_WARN && st_q != ST_LOCK) |=> st_q != ST_WARN);
  // R1: restore request is gone after the first edge
  p_restore_once_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> !restore_o);
endmodule

// File: tb/lock_seq_test.sv
module lock_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_warm = 1'b0, osc_warm = 1'b0, vld = 1'b0;
  logic [15:0] level = '0, sthr = 16'd100, metric = '0;
  logic [15:0] lthr = 16'd4000, wthr = 16'd1000;
  logic [7:0]  flen = 8'd3;
  logic        restore, pfd_wide, max_bw, closed, led;
  logic [1:0]  state;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int m_st = 0, m_left = 0;

  always #4 clk = ~clk;

  lock_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_warm_i(ref_warm), .osc_warm_i(osc_warm),
    .sig_level_i(level), .sig_thr_i(sthr), .metric_vld_i(vld), .metric_i(metric),
    .lock_thr_i(lthr), .warn_thr_i(wthr), .flash_len_i(flen),
    .restore_o(restore), .pfd_wide_o(pfd_wide), .max_bw_o(max_bw),
    .loop_closed_o(closed), .led_o(led), .state_o(state)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // outputs expected for a state code (R3, R5, R8, R9)
  task automatic check_state(string tag, int st);
    check({tag, " state"}, int'(state), st);
    check({tag, " pfd"}, int'(pfd_wide), int'(st <= 1));
    check({tag, " bw"}, int'(max_bw), int'(st <= 1));
    check({tag, " loop"}, int'(closed), int'(st != 0));
    check({tag, " led"}, int'(led), int'(st == 2));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // spec-level next state
  function automatic int next_st(int st, int left);
    bit rdy = ref_warm && osc_warm && (level > sthr);
    case (st)
      0: return rdy ? 1 : 0;
      1: return (vld && metric < lthr) ? 2 : 1;
      2: return (vld && metric > lthr) ? 1 : (vld && metric > wthr) ? 3 : 2;
      default: return (vld && metric > lthr) ? 1 : (left <= 1) ? 2 : 3;
    endcase
  endfunction

  function automatic int eff_len(logic [7:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  task automatic model_step();
    int ns = next_st(m_st, m_left);
    if (ns == 3 && m_st != 3) m_left = eff_len(flen);
    else if (m_st == 3 && ns == 3) m_left--;
    m_st = ns;
    step();
  endtask

  task automatic strobe(logic [15:0] m);
    metric = m; vld = 1'b1;
    step();
    vld = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1 in reset", 0);
    rst_n = 1'b1;
    #1;
    check("R1 restore high", int'(restore), 1);
    step();
    check("R1 restore low", int'(restore), 0);
    check_state("R1 after reset", 0);

    // R2: each condition missing in turn
    ref_warm = 1'b1; osc_warm = 1'b1; level = 16'd100;  // equal, not above
    step(); check_state("R2 level equal", 0);
    level = 16'd500; osc_warm = 1'b0;
    step(); check_state("R2 osc cold", 0);
    osc_warm = 1'b1; ref_warm = 1'b0;
    step(); check_state("R2 ref cold", 0);
    ref_warm = 1'b1;
    step(); check_state("R2 all met / R3", 1);

    // R4: metric without strobe ignored
    metric = 16'd10; vld = 1'b0;
    step(); check_state("R4 no strobe", 1);
    strobe(16'd4000); check_state("R4 at lock thr", 1);
    strobe(16'd3999); check_state("R4 lock / R5", 2);

    // R6 + R8: flash of 3 cycles
    flen = 8'd3;
    strobe(16'd1001); check_state("R6 warn", 3);
    step(); check_state("R8 flash 2", 3);
    step(); check_state("R8 flash 3", 3);
    step(); check_state("R8 back to lock", 2);

    // R6: metric equal to lock threshold is a warning, not a loss
    strobe(16'd4000); check_state("R6 equal lock thr", 3);
    // R7: loss inside flash
    strobe(16'd4001); check_state("R7 lost in warn", 1);
    strobe(16'd0); check_state("R7 relock", 2);
    // R7: loss from lock
    strobe(16'hFFFF); check_state("R7 lost in lock", 1);
    strobe(16'd0);
    // R8: length 0 acts as 1
    flen = 8'd0;
    strobe(16'd2000); check_state("R8 len0 warn", 3);
    step(); check_state("R8 len0 return", 2);

    // random phase against model
    void'($urandom(32'd1234));
    m_st = 2; m_left = 0;
    for (int i = 0; i < 4000; i++) begin
      ref_warm = ($urandom % 8) != 0;
      osc_warm = ($urandom % 8) != 0;
      level    = 16'($urandom % 200);
      vld      = ($urandom % 3) == 0;
      metric   = 16'($urandom % 6000);
      if (m_st != 3 && ($urandom % 16) == 0) flen = 8'($urandom % 7);
      if (m_st != 3 && ($urandom % 64) == 0) begin
        wthr = 16'(500 + $urandom % 1500);
        lthr = wthr + 16'(1 + $urandom % 3000);
      end
      if (($urandom % 500) == 0) begin
        rst_n = 1'b0; #1;
        check_state("R1 random reset", 0);
        @(negedge clk); rst_n = 1'b1; m_st = 0; m_left = 0;
        continue;
      end
      model_step();
      check_state("R9 random", m_st);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule